// File: doc/BRIEF.md
# Four-Channel DMA Bus-Master Controller

This block lets four peripherals move bytes to and from system memory without the processor copying them. Each channel is set up through an 8-bit register port with a 20-bit memory address, a byte count and a direction. When an enabled channel raises its request, the controller asks the processor for the bus with a hold request. It waits for hold acknowledge and then runs one bus cycle per byte. Each bus cycle is an address phase with an address latch enable pulse, followed by a strobe phase. In the strobe phase one I/O strobe and the opposite memory strobe are active together, so the byte passes directly between the device and memory in a single pass. The controller never holds the data.

Channel 0 has the highest fixed priority, and the winner is chosen again at every byte boundary. After each byte the channel's address advances and its count steps down. The byte that ends the count raises a terminal-count pulse. That channel then disables itself and the bus is handed back to the processor.

Top module: `dma4_ctrl`

## Requirements
- R1: After reset the hold request, address latch enable, bus enable and all acknowledges are low, every strobe is high, the address output is zero and all channels are disabled.
- R2: When the controller is idle, hold acknowledge is low and an enabled channel requests, hold request rises. A request from a disabled channel never raises hold request.
- R3: Address latch enable, bus enable, strobes and acknowledges are driven only after hold acknowledge has been sampled high following hold request.
- R4: Every byte takes one address cycle, with address latch enable high and the channel's address driven, followed by one strobe cycle with the same address. In the strobe cycle exactly one acknowledge is high, and it belongs to the channel being served.
- R5: With mode bit 0 set (device to memory), I/O read and memory write are low together in the strobe cycle. With mode bit 0 clear (memory to device), memory read and I/O write are low together.
- R6: Among simultaneous enabled requests the lowest-numbered channel is served first, and priority is re-evaluated after each byte.
- R7: The 20-bit address is the 4-bit page above a 16-bit low part. The low part increments after each byte and wraps from 0xFFFF to 0x0000, and the page never changes. A programmed count of N moves N+1 bytes.
- R8: The terminal-count output is high during the strobe cycle of a channel's last byte. That channel is then disabled, and hold request is low in the next cycle. Later requests from the channel are ignored until it is enabled again.
- R9: reg_addr[3:2] selects the channel and reg_addr[1:0] the field: 0 address, 1 count, 2 page (data bits 3:0), 3 mode (bit 0 direction, bit 1 enable). One shared byte pointer picks the low byte or the high byte for address and count writes and toggles on each such write. A page or mode write returns it to the low byte, and reset clears it.
- R10: While any enabled request remains after a non-final byte and hold acknowledge is high, the next address cycle follows the strobe cycle directly, so the bytes of a burst are two cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Channel select [3:2] and field select [1:0] |
| reg_wdata | input | 8 | Register write data |
| dreq | input | 4 | Per-channel transfer request |
| hlda | input | 1 | Hold acknowledge from the processor |
| hrq | output | 1 | Hold request to the processor |
| dack | output | 4 | Per-channel transfer acknowledge |
| bus_en | output | 1 | Controller is driving the address and strobes |
| ale | output | 1 | Address latch enable, high in the address cycle |
| addr_o | output | 20 | Memory address (page and low part) |
| memr_n | output | 1 | Memory read strobe, active low |
| memw_n | output | 1 | Memory write strobe, active low |
| ior_n | output | 1 | I/O read strobe, active low |
| iow_n | output | 1 | I/O write strobe, active low |
| tc | output | 1 | Terminal count, high in the last byte's strobe cycle |

## Verification
The bench builds the block with its default of four channels, a 16-bit low address, a 4-bit page and a 16-bit count. Because the low address is only 16 bits, start addresses just below 0xFFFF make the wrap with the page held fixed reachable within a few bytes. Counts are kept small, so many multi-channel rounds with randomly gated requests fit in a short run. The same rounds exercise priority at byte boundaries, re-acquisition of the bus after each terminal count, and the shared byte pointer's toggle and clear.

// File: rtl/dma_pkg.sv
package dma_pkg;
    localparam int BYTE_W = 8;
    localparam int LO_W   = 16;
    localparam int PAGE_W = 4;
    localparam int CNT_W  = 16;
    localparam int ADDR_W = PAGE_W + LO_W;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_HOLD = 2'd1,
        S_ADDR = 2'd2,
        S_XFER = 2'd3
    } seq_state_e;

    typedef enum logic [1:0] {
        F_ADDR  = 2'd0,
        F_COUNT = 2'd1,
        F_PAGE  = 2'd2,
        F_MODE  = 2'd3
    } reg_field_e;

    typedef struct packed {
        logic [LO_W-1:0]   lo;
        logic [CNT_W-1:0]  cnt;
        logic [PAGE_W-1:0] page;
        logic              dir;
        logic              en;
    } chan_cfg_t;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
    import dma_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int CSEL_W = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [CSEL_W+1:0]              wr_addr,
    input  logic [BYTE_W-1:0]              wr_data,
    input  logic                           upd,
    input  logic [CSEL_W-1:0]              upd_ch,
    output logic [NCH-1:0]                 en_o,
    output logic [NCH-1:0]                 dir_o,
    output logic [NCH-1:0]                 last_o,
    output logic [NCH-1:0][PAGE_W-1:0]     page_o,
    output logic [NCH-1:0][LO_W-1:0]       lo_o
);
    typedef struct packed {
        chan_cfg_t [NCH-1:0] ch;
        logic                ptr;
    } regs_t;

    regs_t             r_d, r_q;
    reg_field_e        fld;
    logic [CSEL_W-1:0] wsel;

    assign fld  = reg_field_e'(wr_addr[1:0]);
    assign wsel = wr_addr[CSEL_W+1:2];

    always_comb begin
        r_d = r_q;
        if (upd) begin
            r_d.ch[upd_ch].lo = r_q.ch[upd_ch].lo + 1'b1;
            if (r_q.ch[upd_ch].cnt == '0) begin
                r_d.ch[upd_ch].en = 1'b0;
            end else begin
                r_d.ch[upd_ch].cnt = r_q.ch[upd_ch].cnt - 1'b1;
            end
        end
        if (wr_en) begin
            case (fld)
                F_ADDR: begin
                    if (r_q.ptr) r_d.ch[wsel].lo[LO_W-1:BYTE_W] = wr_data;
                    else         r_d.ch[wsel].lo[BYTE_W-1:0]    = wr_data;
                    r_d.ptr = ~r_q.ptr;
                end
                F_COUNT: begin
                    if (r_q.ptr) r_d.ch[wsel].cnt[CNT_W-1:BYTE_W] = wr_data;
                    else         r_d.ch[wsel].cnt[BYTE_W-1:0]     = wr_data;
                    r_d.ptr = ~r_q.ptr;
                end
                F_PAGE: begin
                    r_d.ch[wsel].page = wr_data[PAGE_W-1:0];
                    r_d.ptr = 1'b0;
                end
                F_MODE: begin
                    r_d.ch[wsel].dir = wr_data[0];
                    r_d.ch[wsel].en  = wr_data[1];
                    r_d.ptr = 1'b0;
                end
                default: r_d.ptr = r_q.ptr;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign en_o[g]   = r_q.ch[g].en;
        assign dir_o[g]  = r_q.ch[g].dir;
        assign last_o[g] = (r_q.ch[g].cnt == '0);
        assign page_o[g] = r_q.ch[g].page;
        assign lo_o[g]   = r_q.ch[g].lo;

        // R7: a non-final byte steps the count down by one
        a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
            (upd && upd_ch == CSEL_W'(g) && !wr_en && r_q.ch[g].cnt != '0)
            |=> r_q.ch[g].cnt == $past(r_q.ch[g].cnt) - 1'b1);

        // R7: the page is untouched by transfers
        a_r7_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
            (upd && !wr_en) |=> $stable(r_q.ch[g].page));

        // R8: the final byte disables the channel
        a_r8_disable_at_tc: assert property (@(posedge clk) disable iff (!rst_n)
            (upd && upd_ch == CSEL_W'(g) && !wr_en && r_q.ch[g].cnt == '0)
            |=> !r_q.ch[g].en);
    end
endmodule

// File: rtl/dma_arb.sv
module dma_arb #(
    parameter int NCH    = 4,
    parameter int CSEL_W = 2
) (
    input  logic [NCH-1:0]    req,
    output logic              any_o,
    output logic [CSEL_W-1:0] idx_o
);
    always_comb begin
        any_o = |req;
        idx_o = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) idx_o = CSEL_W'(i);
        end
    end

    // R6: the chosen channel requests and no lower-numbered one does
    always_comb begin
        a_r6_lowest_wins: assert (!any_o ||
            (req[idx_o] && ((req & ((NCH'(1) << idx_o) - NCH'(1))) == '0)));
    end
endmodule

// File: rtl/dma_seq.sv
module dma_seq
    import dma_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int CSEL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hlda,
    input  logic              any_req,
    input  logic [CSEL_W-1:0] win,
    input  logic              sel_last,
    input  logic              sel_dir,
    output logic [CSEL_W-1:0] chan_o,
    output logic              upd_o,
    output logic              hrq,
    output logic              bus_en,
    output logic              ale,
    output logic              tc,
    output logic [NCH-1:0]    dack,
    output logic              memr_n,
    output logic              memw_n,
    output logic              ior_n,
    output logic              iow_n
);
    typedef struct packed {
        seq_state_e        st;
        logic [CSEL_W-1:0] ch;
    } seq_t;

    seq_t s_d, s_q;
    logic xfer;

    always_comb begin
        s_d   = s_q;
        upd_o = 1'b0;
        case (s_q.st)
            S_IDLE: if (any_req && !hlda) s_d.st = S_HOLD;
            S_HOLD: begin
                if (!any_req) begin
                    s_d.st = S_IDLE;
                end else if (hlda) begin
                    s_d.st = S_ADDR;
                    s_d.ch = win;
                end
            end
            S_ADDR: s_d.st = S_XFER;
            S_XFER: begin
                upd_o = 1'b1;
                if (!sel_last && any_req && hlda) begin
                    s_d.st = S_ADDR;
                    s_d.ch = win;
                end else begin
                    s_d.st = S_IDLE;
                end
            end
            default: s_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: S_IDLE, ch: '0};
        else        s_q <= s_d;
    end

    assign xfer   = (s_q.st == S_XFER);
    assign chan_o = s_q.ch;
    assign hrq    = (s_q.st != S_IDLE);
    assign ale    = (s_q.st == S_ADDR);
    assign bus_en = ale || xfer;
    assign tc     = xfer && sel_last;
    assign ior_n  = !(xfer && sel_dir);
    assign memw_n = !(xfer && sel_dir);
    assign memr_n = !(xfer && !sel_dir);
    assign iow_n  = !(xfer && !sel_dir);

    always_comb begin
        dack = '0;
        if (xfer) dack[s_q.ch] = 1'b1;
    end

    // R3: the bus is taken only after acknowledge was seen
    a_r3_bus_after_hlda: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_en) |-> $past(hlda));

    // R2: hold request rises only on an enabled request
    a_r2_hold_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hrq) |-> $past(any_req));

    // R8: terminal count hands the bus back
    a_r8_tc_release: assert property (@(posedge clk) disable iff (!rst_n)
        tc |=> !hrq);
endmodule

// File: rtl/dma4_ctrl.sv
module dma4_ctrl
    import dma_pkg::*;
#(
    parameter int NCH = 4,
    localparam int CSEL_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [CSEL_W+1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    input  logic [NCH-1:0]    dreq,
    input  logic              hlda,
    output logic              hrq,
    output logic [NCH-1:0]    dack,
    output logic              bus_en,
    output logic              ale,
    output logic [ADDR_W-1:0] addr_o,
    output logic              memr_n,
    output logic              memw_n,
    output logic              ior_n,
    output logic              iow_n,
    output logic              tc
);
    logic [NCH-1:0]             en, dir, last, masked;
    logic [NCH-1:0][PAGE_W-1:0] page;
    logic [NCH-1:0][LO_W-1:0]   lo;
    logic                       any_req, upd;
    logic [CSEL_W-1:0]          win, chan;

    dma_regs #(.NCH(NCH), .CSEL_W(CSEL_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_we), .wr_addr(reg_addr), .wr_data(reg_wdata),
        .upd(upd), .upd_ch(chan),
        .en_o(en), .dir_o(dir), .last_o(last), .page_o(page), .lo_o(lo)
    );

    assign masked = dreq & en;

    dma_arb #(.NCH(NCH), .CSEL_W(CSEL_W)) u_arb (
        .req(masked), .any_o(any_req), .idx_o(win)
    );

    dma_seq #(.NCH(NCH), .CSEL_W(CSEL_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .hlda(hlda),
        .any_req(any_req), .win(win),
        .sel_last(last[chan]), .sel_dir(dir[chan]),
        .chan_o(chan), .upd_o(upd),
        .hrq(hrq), .bus_en(bus_en), .ale(ale), .tc(tc), .dack(dack),
        .memr_n(memr_n), .memw_n(memw_n), .ior_n(ior_n), .iow_n(iow_n)
    );

    assign addr_o = bus_en ? {page[chan], lo[chan]} : '0;

    // R4: an address cycle is followed by a strobe cycle on the same address
    a_r4_ale_then_dack: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> (dack != '0) && $stable(addr_o));

    // R4: acknowledges are one-hot and only with a strobe
    a_r4_dack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dack) && ((dack != '0) == (!memr_n || !memw_n)));

    // R5: device-to-memory pairing
    a_r5_write_pair: assert property (@(posedge clk) disable iff (!rst_n)
        !memw_n |-> (!ior_n && memr_n && iow_n));

    // R5: memory-to-device pairing
    a_r5_read_pair: assert property (@(posedge clk) disable iff (!rst_n)
        !memr_n |-> (!iow_n && memw_n && ior_n));
endmodule

// File: tb/tb_dma4_ctrl.sv
`timescale 1ns/1ps
module tb_dma4_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [3:0]  dreq;
    logic        hlda = 1'b0;
    logic        hrq, bus_en, ale, memr_n, memw_n, ior_n, iow_n, tc;
    logic [3:0]  dack;
    logic [19:0] addr_o;

    logic [3:0]  want = '0;
    logic [3:0]  gate = 4'hF;
    bit          gate_rand = 1'b0;
    int          left [4];
    logic [15:0] exp_lo [4];
    logic [3:0]  exp_pg [4];
    logic        exp_dir [4];
    int          order [$];
    int          stamps [$];
    int          errs = 0, checks = 0, cyc = 0;
    logic        prev_ale = 1'b0;
    logic [19:0] prev_addr = '0;

    dma4_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .dreq(dreq), .hlda(hlda), .hrq(hrq),
        .dack(dack), .bus_en(bus_en), .ale(ale), .addr_o(addr_o),
        .memr_n(memr_n), .memw_n(memw_n), .ior_n(ior_n), .iow_n(iow_n),
        .tc(tc)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        hlda <= rst_n ? hrq : 1'b0;
    end

    always_comb begin
        for (int i = 0; i < 4; i++) dreq[i] = want[i] && (left[i] != 0) && gate[i];
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [19:0] exp_addr(input int c);
        return {exp_pg[c], exp_lo[c]};
    endfunction

    // bus monitor and device model
    always @(negedge clk) begin
        if (rst_n) begin
            if (!memr_n || !memw_n || !ior_n || !iow_n) begin
                int c = 0;
                for (int i = 0; i < 4; i++) if (dack[i]) c = i;
                chk($onehot(dack), "R4", "dack one-hot", dack, 4'b0001 << c);
                chk(prev_ale && prev_addr == addr_o, "R4", "address cycle before strobe",
                    prev_addr, addr_o);
                chk(hlda, "R3", "hlda during strobe", hlda, 1);
                chk(addr_o == exp_addr(c), "R7", "byte address", addr_o, exp_addr(c));
                if (exp_dir[c])
                    chk(!ior_n && !memw_n && memr_n && iow_n, "R5", "dev-to-mem strobes",
                        {memr_n, memw_n, ior_n, iow_n}, 4'b1001);
                else
                    chk(!memr_n && !iow_n && memw_n && ior_n, "R5", "mem-to-dev strobes",
                        {memr_n, memw_n, ior_n, iow_n}, 4'b0110);
                chk(tc == (left[c] == 1), "R8", "terminal count flag", tc, left[c] == 1);
                if (left[c] > 0) left[c] = left[c] - 1;
                exp_lo[c] = exp_lo[c] + 16'd1;
                order.push_back(c);
                stamps.push_back(cyc);
            end
            prev_ale  = ale;
            prev_addr = addr_o;
            gate <= gate_rand ? 4'($urandom) : 4'hF;
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic prog(input int c, input logic [3:0] pg, input logic [15:0] lo,
                        input logic [15:0] cnt, input logic d, input logic en);
        logic [1:0] cs = 2'(c);
        wr({cs, 2'd2}, {4'h0, pg});
        wr({cs, 2'd0}, lo[7:0]);
        wr({cs, 2'd0}, lo[15:8]);
        wr({cs, 2'd1}, cnt[7:0]);
        wr({cs, 2'd1}, cnt[15:8]);
        wr({cs, 2'd3}, {6'd0, en, d});
        exp_pg[c] = pg; exp_lo[c] = lo; exp_dir[c] = d;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while ((left[0] + left[1] + left[2] + left[3]) != 0 && n < 5000) begin
            @(negedge clk); n++;
        end
        chk(n < 5000, req, "all bytes moved", n, 0);
        repeat (3) @(negedge clk);
        chk(!hrq, "R8", "hold released after completion", hrq, 0);
        @(posedge clk); #1;
        want = '0;
        for (int i = 0; i < 4; i++) left[i] = 0;
    endtask

    task automatic check_ignored(input int c, input string req);
        bit seen = 1'b0;
        @(posedge clk); #1;
        left[c] = 1; want[c] = 1'b1;
        repeat (10) begin
            @(negedge clk);
            if (hrq) seen = 1'b1;
        end
        chk(!seen, req, "request of disabled channel ignored", seen, 0);
        @(posedge clk); #1;
        want[c] = 1'b0; left[c] = 0;
    endtask

    initial begin
        int total;
        for (int i = 0; i < 4; i++) begin
            left[i] = 0; exp_lo[i] = '0; exp_pg[i] = '0; exp_dir[i] = 1'b0;
        end
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!hrq && !ale && !bus_en && dack == '0, "R1", "control outputs after reset",
            {hrq, ale, bus_en, dack}, 0);
        chk(memr_n && memw_n && ior_n && iow_n, "R1", "strobes high after reset",
            {memr_n, memw_n, ior_n, iow_n}, 4'hF);
        chk(addr_o == '0, "R1", "address after reset", addr_o, 0);
        for (int c = 0; c < 4; c++) check_ignored(c, "R1");

        // single device-to-memory burst, back-to-back spacing
        prog(2, 4'h5, 16'h1234, 16'd3, 1'b1, 1'b1);
        stamps.delete(); order.delete();
        @(posedge clk); #1;
        left[2] = 4; want[2] = 1'b1;
        @(negedge clk); @(negedge clk);
        chk(hrq, "R2", "hold request after enabled request", hrq, 1);
        wait_done("R7");
        chk(order.size() == 4, "R7", "count 3 moves four bytes", order.size(), 4);
        for (int i = 0; i + 1 < stamps.size(); i++)
            chk(stamps[i+1] - stamps[i] == 2, "R10", "burst spacing",
                stamps[i+1] - stamps[i], 2);
        check_ignored(2, "R8");

        // memory-to-device, count zero
        prog(0, 4'h3, 16'h0040, 16'd0, 1'b0, 1'b1);
        order.delete();
        @(posedge clk); #1; left[0] = 1; want[0] = 1'b1;
        wait_done("R5");
        chk(order.size() == 1, "R7", "count 0 moves one byte", order.size(), 1);

        // low address wrap with page held
        prog(1, 4'hA, 16'hFFFE, 16'd3, 1'b1, 1'b1);
        @(posedge clk); #1; left[1] = 4; want[1] = 1'b1;
        wait_done("R7");

        // priority among simultaneous requests
        prog(1, 4'h1, 16'h0100, 16'd0, 1'b0, 1'b1);
        prog(2, 4'h2, 16'h0200, 16'd0, 1'b1, 1'b1);
        prog(3, 4'h3, 16'h0300, 16'd0, 1'b0, 1'b1);
        order.delete();
        @(posedge clk); #1;
        left[1] = 1; left[2] = 1; left[3] = 1; want = 4'b1110;
        wait_done("R6");
        chk(order.size() == 3 && order[0] == 1 && order[1] == 2 && order[2] == 3,
            "R6", "service order 1,2,3", order.size() == 3 ? order[0] * 16 + order[1] : -1, 8'h12);
        prog(0, 4'h0, 16'h0500, 16'd1, 1'b1, 1'b1);
        prog(2, 4'h2, 16'h0600, 16'd0, 1'b1, 1'b1);
        order.delete();
        @(posedge clk); #1;
        left[0] = 2; left[2] = 1; want = 4'b0101;
        wait_done("R6");
        chk(order.size() == 3 && order[0] == 0 && order[1] == 0 && order[2] == 2,
            "R6", "service order 0,0,2", order.size() == 3 ? order[2] : -1, 2);

        // byte pointer toggling and clearing
        prog(3, 4'h6, 16'h5566, 16'd1, 1'b0, 1'b0);
        wr({2'd3, 2'd2}, 8'h06);
        wr({2'd3, 2'd0}, 8'h11);
        wr({2'd3, 2'd2}, 8'h06);
        wr({2'd3, 2'd0}, 8'h77);
        wr({2'd3, 2'd1}, 8'h00);
        wr({2'd3, 2'd3}, 8'h02);
        exp_lo[3] = 16'h5577;
        order.delete();
        @(posedge clk); #1; left[3] = 2; want[3] = 1'b1;
        wait_done("R9");
        chk(order.size() == 2, "R9", "count high byte written, low kept", order.size(), 2);

        // random rounds
        gate_rand = 1'b1;
        for (int r = 0; r < 40; r++) begin
            logic [3:0] m = 4'($urandom);
            if (m == 0) m = 4'b0001 << ($urandom % 4);
            total = 0;
            order.delete();
            for (int c = 0; c < 4; c++) begin
                if (m[c]) begin
                    logic [15:0] lo = ($urandom % 2) ? 16'($urandom) : (16'hFFF8 + 16'($urandom % 8));
                    logic [15:0] cn = 16'($urandom % 7);
                    prog(c, 4'($urandom), lo, cn, 1'($urandom), 1'b1);
                    left[c] = int'(cn) + 1;
                    total += int'(cn) + 1;
                end
            end
            @(posedge clk); #1; want = m;
            wait_done("R7");
            chk(order.size() == total, "R7", "random round byte total", order.size(), total);
        end
        gate_rand = 1'b0;

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        errs++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule